// File: doc/BRIEF.md
# Ternary Data Slicer and Chip Decoder

This block turns a stream of signed filter output samples, one per chip or bit period, into binary decisions. A valid strobe marks each sample, and the decision comes out one clock later with its own strobe. A mode input selects between two ways of slicing.

In chip mode, each sample is compared against a symmetric band around zero whose half-width is programmable. Samples clearly positive become chip 1 and samples clearly negative become chip 0. A sample inside the band carries no polarity. It is read as a chip transition, so the output is the complement of the previously decoded chip. This keeps Manchester code violations visible to downstream logic.

In bit mode, the band is not used and only the sign of the sample decides. This gives full sensitivity when code violations do not matter. A diagnostic output marks every decision that was resolved from the previous chip, so downstream logic can count zero-band events.

Top module: `chip_slicer`

## Requirements
- R1: In bit mode (`chip_mode`=0) the decision is 1 when the sample is greater than or equal to zero and 0 when it is negative, whatever the value of `zero_thr`.
- R2: In chip mode (`chip_mode`=1) a sample strictly greater than `zero_thr` gives decision 1.
- R3: In chip mode a sample strictly less than the negation of `zero_thr` gives decision 0.
- R4: In chip mode a sample in the inclusive range from -`zero_thr` to +`zero_thr` gives the complement of the previously decoded chip. A sample exactly at either bound counts as inside this range.
- R5: The previous-chip state is 0 after reset, so the first in-band chip-mode sample after reset gives 1.
- R6: The previous-chip state and `out_chip` change only on valid samples. Cycles without `in_valid` leave `out_chip` unchanged and do not affect later in-band decisions.
- R7: A change of `chip_mode` clears the previous-chip state to 0.
- R8: `out_valid` is `in_valid` delayed by exactly one clock cycle, and the decision for a sample appears on `out_chip` in that same cycle.
- R9: `out_resolved` is 1 together with `out_valid` exactly when the decision came from a chip-mode in-band sample. It is 0 in bit mode and for all other samples.
- R10: With `zero_thr`=0 in chip mode, only a sample of exactly 0 lies in the band.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample strobe |
| in_sample | input | W | Signed filter output sample |
| zero_thr | input | W | Unsigned half-width of the zero band |
| chip_mode | input | 1 | 1 = chip mode with zero band, 0 = bit mode (sign only) |
| out_valid | output | 1 | Decision strobe, one cycle after `in_valid` |
| out_chip | output | 1 | Decided chip or bit |
| out_resolved | output | 1 | Decision was taken from the previous chip |

## Verification
The bench applies samples well above and well below the band, samples exactly on both bounds and one step outside them, and runs of consecutive in-band samples. The bound cases separate inclusive comparison from exclusive comparison. The runs show whether an in-band decision really toggles against the stored chip.

Bit mode is driven with a large threshold and samples of zero and minus one. This shows that the band is ignored and that zero counts as positive.

Gaps without `in_valid` and mode switches are placed between in-band samples. A stale previous chip would then give the opposite decision from a correctly held or cleared one.

// File: rtl/chip_slicer.sv
module chip_slicer #(
  parameter int W = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic signed [W-1:0] in_sample,
  input  logic        [W-1:0] zero_thr,
  input  logic                chip_mode,
  output logic                out_valid,
  output logic                out_chip,
  output logic                out_resolved
);

  localparam int XW = W + 1;

  logic mode_q, prev_q;
  logic signed [XW-1:0] s_ext, t_pos, t_neg;
  logic above, below, in_band, mode_chg, prev_eff, next_chip;

  assign s_ext    = {in_sample[W-1], in_sample};
  assign t_pos    = {1'b0, zero_thr};
  assign t_neg    = -t_pos;
  assign above    = s_ext > t_pos;
  assign below    = s_ext < t_neg;
  assign in_band  = chip_mode & ~above & ~below;
  assign mode_chg = chip_mode != mode_q;
  assign prev_eff = mode_chg ? 1'b0 : prev_q;

  always_comb begin
    if (!chip_mode)  next_chip = ~in_sample[W-1];
    else if (above)  next_chip = 1'b1;
    else if (below)  next_chip = 1'b0;
    else             next_chip = ~prev_eff;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q       <= 1'b0;
      prev_q       <= 1'b0;
      out_valid    <= 1'b0;
      out_chip     <= 1'b0;
      out_resolved <= 1'b0;
    end else begin
      mode_q       <= chip_mode;
      out_valid    <= in_valid;
      out_resolved <= in_valid & in_band;
      if (in_valid) begin
        prev_q   <= next_chip;
        out_chip <= next_chip;
      end else if (mode_chg) begin
        prev_q <= 1'b0;
      end
    end
  end

  // R8
  valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R9
  resolved_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_resolved |-> out_valid);

  // R9
  bit_no_resolve_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !chip_mode) |=> !out_resolved);

  // R2
  above_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && chip_mode && above) |=> out_chip);

  // R4
  band_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_band && !mode_chg) |=> (out_chip != $past(prev_q)));

  // R6
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_chip));

endmodule

// File: tb/chip_slicer_tb.sv
module chip_slicer_tb;
  localparam int W = 12;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic signed [W-1:0] in_sample = '0;
  logic [W-1:0] zero_thr = '0;
  logic chip_mode = 1'b0;
  logic out_valid, out_chip, out_resolved;

  int n_run = 0, n_fail = 0;
  bit prev_m = 1'b0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  chip_slicer #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
    .zero_thr(zero_thr), .chip_mode(chip_mode), .out_valid(out_valid),
    .out_chip(out_chip), .out_resolved(out_resolved));

  task automatic check(string tag, logic act, logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic set_mode(bit m);
    @(negedge clk);
    if (m != chip_mode) prev_m = 1'b0;
    chip_mode = m;
    @(negedge clk);
  endtask

  task automatic send(string tag, int s);
    int t;
    bit e, r;
    t = int'(zero_thr);
    if (!chip_mode) begin e = (s >= 0); r = 1'b0; end
    else if (s > t) begin e = 1'b1; r = 1'b0; end
    else if (s < -t) begin e = 1'b0; r = 1'b0; end
    else begin e = ~prev_m; r = 1'b1; end
    prev_m = e;
    @(negedge clk);
    in_sample = W'(s);
    in_valid = 1'b1;
    @(negedge clk);
    check({tag, " R8 valid"}, out_valid, 1'b1);
    check({tag, " chip"}, out_chip, e);
    check({tag, " R9 resolved"}, out_resolved, r);
    in_valid = 1'b0;
    in_sample = W'(-s);
    @(negedge clk);
    check({tag, " R8 idle"}, out_valid, 1'b0);
    check({tag, " R6 hold"}, out_chip, e);
  endtask

  task automatic t_reset();
    check("R5 reset valid", out_valid, 1'b0);
    check("R5 reset chip", out_chip, 1'b0);
    check("R5 reset resolved", out_resolved, 1'b0);
  endtask

  task automatic t_first_band();
    zero_thr = 12'd100;
    set_mode(1'b1);
    send("R5 first band", 0);
  endtask

  task automatic t_bit_mode();
    set_mode(1'b0);
    zero_thr = 12'd2000;
    send("R1 zero", 0);
    send("R1 minus one", -1);
    send("R1 small pos", 5);
    send("R1 neg max", -2048);
    send("R1 pos max", 2047);
  endtask

  task automatic t_chip_levels();
    set_mode(1'b1);
    zero_thr = 12'd100;
    send("R2 above", 101);
    send("R2 far above", 2047);
    send("R3 below", -101);
    send("R3 far below", -2048);
  endtask

  task automatic t_band_bounds();
    zero_thr = 12'd100;
    send("R4 upper bound", 100);
    send("R4 lower bound", -100);
    send("R4 run", 3);
    send("R4 run2", -7);
    send("R3 reset toggle", -300);
    send("R4 after low", 50);
  endtask

  task automatic t_gap();
    send("R6 set one", 500);
    repeat (4) @(negedge clk);
    check("R6 gap hold", out_chip, 1'b1);
    send("R6 band after gap", 0);
  endtask

  task automatic t_mode_change();
    send("R7 set one", 400);
    set_mode(1'b0);
    set_mode(1'b1);
    send("R7 band after switch", 0);
    send("R7 set one again", 400);
    set_mode(1'b0);
    send("R7 bit neg", -4);
    set_mode(1'b1);
    send("R7 band after bit", 10);
  endtask

  task automatic t_zero_thr();
    zero_thr = '0;
    send("R10 one", 1);
    send("R10 minus one", -1);
    send("R10 zero", 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_first_band();
    t_bit_mode();
    t_chip_levels();
    t_band_bounds();
    t_gap();
    t_mode_change();
    t_zero_thr();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule